// File: doc/BRIEF.md
# Four-Channel DMA Register Controller

This block holds the programming registers and transfer counters of a four-channel, byte-wide DMA controller. Each channel has a 16-bit base and current address, a 16-bit base and current count, a 4-bit page and a mode setting. The channels share a command register, a status register, a mask set, a software request set and one byte pointer. The byte pointer carries every 16-bit register through the 8-bit register port, one byte per access.

When a channel is unmasked and the controller is enabled, a request on that channel is granted. Requests come from its request pin or from the software request register. A grant runs exactly one transfer. For that transfer the block raises the matching acknowledge line for one cycle and presents a 20-bit memory address, made of the channel's page and its current 16-bit address. It also presents the transfer type from the channel's mode. The address then steps up or down and the count steps down.

A count programmed as N-1 gives N transfers. The last transfer flags terminal count. At terminal count the channel either reloads its base values (auto-initialisation) or masks itself.

Top module: `dma4_ctrl`

## Requirements
- R1: After reset the acknowledge lines are low, the status register reads 0x00, all four channels are masked, and the byte pointer selects the low byte.
- R2: Registers 0x00-0x07 form the channel registers. Channel c has its address at offset 2c and its count at 2c+1. Each is accessed one byte per write or read: first the low byte, then the high byte, with one shared byte pointer that toggles on every access to any of them.
- R3: Any write to offset 0x0C returns the byte pointer to the low byte.
- R4: Writing a byte of a base address or count writes the same byte of the current address or count. Reads return the current value.
- R5: A write to offset 0x0B sets the mode of channel wdata[1:0]. Bits 3:2 give the transfer type, which appears on xfer_kind during the acknowledge (00 verify, 01 write, 10 read). Bit 4 enables auto-initialisation. Bit 5 set makes the address count down; clear makes it count up. Bits 7:6 give the service mode.
- R6: A write to offset 0x0A masks channel wdata[1:0] when wdata[2] is 1 and unmasks it when wdata[2] is 0. A masked channel receives no acknowledge.
- R7: A write to 0x0F loads all four masks from wdata[3:0]. A write to 0x0E unmasks all four channels. A write to 0x0D (master clear) masks all channels and clears the command, status flags, software requests and byte pointer.
- R8: While command bit 2 (written at offset 0x08) is 1, no channel is granted.
- R9: A write to offset 0x10+c sets the 4-bit page of channel c. mem_addr is {page, current address}. Stepping past 0xFFFF or 0x0000 wraps inside the 16 bits and leaves the page unchanged.
- R10: A count programmed as N-1 gives N transfers. tc is high together with the acknowledge of the last one, which is the transfer made while the current count is zero.
- R11: A status read (offset 0x08) returns terminal-count flags for channels 0-3 in bits 3:0 and pending requests (pin or software) in bits 7:4. The read clears bits 3:0.
- R12: After terminal count a channel without auto-initialisation masks itself. A channel with auto-initialisation reloads its base address and count and stays unmasked.
- R13: The lowest-numbered requesting channel wins. Each grant gives one acknowledge lasting one cycle, and no acknowledge follows directly in the next cycle.
- R14: A write to offset 0x09 sets (wdata[2]=1) or clears (wdata[2]=0) the software request of channel wdata[1:0]. Terminal count on that channel also clears it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_addr | input | 5 | Register offset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data, valid the cycle after reg_rd |
| dreq | input | 4 | Per-channel transfer request |
| dack | output | 4 | Per-channel acknowledge, one cycle per transfer |
| mem_addr | output | 20 | Memory address of the current transfer |
| xfer_kind | output | 2 | Transfer type of the current transfer |
| tc | output | 1 | Terminal count, with the acknowledge of the last transfer |

## Verification
A register write takes effect at the clock edge on which its strobe is seen. Read data appears on reg_rdata at the edge after the read strobe, and the byte pointer and status flags change at that same edge. A request seen at one edge yields dack, mem_addr, xfer_kind and tc at that edge, and the next grant can come no sooner than two edges later. The bench drives every strobe and request on the falling edge and reads results on the falling edge that follows. It records each acknowledge cycle by cycle, so it can compare addresses, spacing, order and terminal-count position against values it computes itself.

// File: rtl/dma4_pkg.sv
package dma4_pkg;
    localparam int NUM_CH = 4;
    localparam int CH_W   = $clog2(NUM_CH);
    localparam int BYTE_W = 8;
    localparam int WORD_W = 2 * BYTE_W;
    localparam int PAGE_W = 4;
    localparam int MEM_W  = WORD_W + PAGE_W;
    localparam int OFS_W  = 5;

    localparam logic [OFS_W-1:0] OFS_CMD_STAT = 5'h08;
    localparam logic [OFS_W-1:0] OFS_SWREQ    = 5'h09;
    localparam logic [OFS_W-1:0] OFS_ONEMASK  = 5'h0A;
    localparam logic [OFS_W-1:0] OFS_MODE     = 5'h0B;
    localparam logic [OFS_W-1:0] OFS_PTRCLR   = 5'h0C;
    localparam logic [OFS_W-1:0] OFS_RESETALL = 5'h0D;
    localparam logic [OFS_W-1:0] OFS_UNMASK   = 5'h0E;
    localparam logic [OFS_W-1:0] OFS_ALLMASK  = 5'h0F;
    localparam logic [OFS_W-1:0] OFS_PAGE0    = 5'h10;

    typedef enum logic [1:0] {
        KIND_VERIFY = 2'b00,
        KIND_WRITE  = 2'b01,
        KIND_READ   = 2'b10,
        KIND_RSVD   = 2'b11
    } xfer_kind_e;

    typedef enum logic [1:0] {
        SVC_DEMAND  = 2'b00,
        SVC_SINGLE  = 2'b01,
        SVC_BLOCK   = 2'b10,
        SVC_CASCADE = 2'b11
    } svc_mode_e;

    // Packed to match bits 7:2 of a mode write.
    typedef struct packed {
        svc_mode_e  svc;
        logic       down;
        logic       auto_init;
        xfer_kind_e kind;
    } chan_mode_t;

    typedef enum logic {
        PH_IDLE = 1'b0,
        PH_ACK  = 1'b1
    } phase_e;

    function automatic logic [NUM_CH-1:0] sel_to_vec(input logic [CH_W-1:0] sel);
        logic [NUM_CH-1:0] v;
        v = '0;
        v[sel] = 1'b1;
        return v;
    endfunction

    function automatic logic [CH_W-1:0] vec_to_sel(input logic [NUM_CH-1:0] v);
        logic [CH_W-1:0] s;
        s = '0;
        for (int i = 0; i < NUM_CH; i++) begin
            if (v[i]) s = CH_W'(i);
        end
        return s;
    endfunction
endpackage

// File: rtl/dma4_chan.sv
module dma4_chan
    import dma4_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_addr,
    input  logic              wr_cnt,
    input  logic              hi_byte,
    input  logic [BYTE_W-1:0] wdata,
    input  logic              step,
    input  logic              down,
    input  logic              auto_init,
    output logic [WORD_W-1:0] cur_addr,
    output logic [WORD_W-1:0] cur_cnt,
    output logic              tc_hit
);
    logic [WORD_W-1:0] base_addr;
    logic [WORD_W-1:0] base_cnt;

    assign tc_hit = step && (cur_cnt == '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            base_addr <= '0;
            base_cnt  <= '0;
            cur_addr  <= '0;
            cur_cnt   <= '0;
        end else begin
            if (step) begin
                if (tc_hit && auto_init) begin
                    cur_addr <= base_addr;
                    cur_cnt  <= base_cnt;
                end else begin
                    cur_addr <= down ? cur_addr - 1'b1 : cur_addr + 1'b1;
                    cur_cnt  <= cur_cnt - 1'b1;
                end
            end
            if (wr_addr) begin
                if (hi_byte) begin
                    base_addr[WORD_W-1:BYTE_W] <= wdata;
                    cur_addr[WORD_W-1:BYTE_W]  <= wdata;
                end else begin
                    base_addr[BYTE_W-1:0] <= wdata;
                    cur_addr[BYTE_W-1:0]  <= wdata;
                end
            end
            if (wr_cnt) begin
                if (hi_byte) begin
                    base_cnt[WORD_W-1:BYTE_W] <= wdata;
                    cur_cnt[WORD_W-1:BYTE_W]  <= wdata;
                end else begin
                    base_cnt[BYTE_W-1:0] <= wdata;
                    cur_cnt[BYTE_W-1:0]  <= wdata;
                end
            end
        end
    end

    AST_COUNT_STEPS: assert property (@(posedge clk) disable iff (rst)
        (step && !tc_hit && !wr_cnt) |=> (cur_cnt == WORD_W'($past(cur_cnt) - 1'b1))); // R10
    AST_AUTO_RELOAD: assert property (@(posedge clk) disable iff (rst)
        (step && tc_hit && auto_init && !wr_addr && !wr_cnt) |=>
        (cur_cnt == base_cnt && cur_addr == base_addr)); // R12
endmodule

// File: rtl/dma4_arb.sv
module dma4_arb #(
    parameter int N = 4
) (
    input  logic [N-1:0] req,
    output logic [N-1:0] grant
);
    logic [N-1:0] neg_req;

    // Isolate the lowest set bit: lowest index wins.
    assign neg_req = ~req + {{(N-1){1'b0}}, 1'b1};
    assign grant   = req & neg_req;
endmodule

// File: rtl/dma4_ctrl.sv
module dma4_ctrl
    import dma4_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic [OFS_W-1:0]    reg_addr,
    input  logic                reg_wr,
    input  logic                reg_rd,
    input  logic [BYTE_W-1:0]   reg_wdata,
    output logic [BYTE_W-1:0]   reg_rdata,
    input  logic [NUM_CH-1:0]   dreq,
    output logic [NUM_CH-1:0]   dack,
    output logic [MEM_W-1:0]    mem_addr,
    output logic [1:0]          xfer_kind,
    output logic                tc
);
    localparam int CMD_OFF_BIT = 2;

    // Register state
    logic [BYTE_W-1:0] cmd_q;
    logic [NUM_CH-1:0] mask_q, mask_d;
    logic [NUM_CH-1:0] swreq_q, swreq_d;
    logic [NUM_CH-1:0] tcflag_q;
    logic              ptr_hi_q;
    phase_e            phase_q;
    chan_mode_t        mode_q [NUM_CH];
    logic [PAGE_W-1:0] page_q [NUM_CH];

    // Channel datapath
    logic [WORD_W-1:0] cur_addr [NUM_CH];
    logic [WORD_W-1:0] cur_cnt  [NUM_CH];
    logic [NUM_CH-1:0] tc_hit;
    logic [NUM_CH-1:0] auto_vec;
    logic [NUM_CH-1:0] elig, grant;
    logic [CH_W-1:0]   gsel;

    // Decode
    logic chan_reg, page_reg, wr_at, rd_stat, clr_all;
    logic [CH_W-1:0] reg_ch;
    assign chan_reg = (reg_addr[OFS_W-1:3] == '0);
    assign page_reg = (reg_addr[OFS_W-1:CH_W] == OFS_PAGE0[OFS_W-1:CH_W]);
    assign reg_ch   = reg_addr[CH_W:1];
    assign wr_at    = reg_wr;
    assign rd_stat  = reg_rd && (reg_addr == OFS_CMD_STAT);
    assign clr_all  = wr_at && (reg_addr == OFS_RESETALL);

    logic [CH_W-1:0] wsel;
    assign wsel = reg_wdata[CH_W-1:0];

    // Channel instances
    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        logic we_addr, we_cnt;
        assign we_addr     = wr_at && chan_reg && (reg_ch == CH_W'(c)) && !reg_addr[0];
        assign we_cnt      = wr_at && chan_reg && (reg_ch == CH_W'(c)) &&  reg_addr[0];
        assign auto_vec[c] = mode_q[c].auto_init;

        dma4_chan u_chan (
            .clk       (clk),
            .rst       (rst),
            .wr_addr   (we_addr),
            .wr_cnt    (we_cnt),
            .hi_byte   (ptr_hi_q),
            .wdata     (reg_wdata),
            .step      (grant[c]),
            .down      (mode_q[c].down),
            .auto_init (mode_q[c].auto_init),
            .cur_addr  (cur_addr[c]),
            .cur_cnt   (cur_cnt[c]),
            .tc_hit    (tc_hit[c])
        );
    end

    // Arbitration
    assign elig = (dreq | swreq_q) & ~mask_q
                & {NUM_CH{~cmd_q[CMD_OFF_BIT]}}
                & {NUM_CH{phase_q == PH_IDLE}};

    dma4_arb #(.N(NUM_CH)) u_arb (
        .req   (elig),
        .grant (grant)
    );

    assign gsel = vec_to_sel(grant);

    // Mask and software request next state
    always_comb begin
        mask_d  = mask_q;
        swreq_d = swreq_q;
        if (wr_at) begin
            unique case (reg_addr)
                OFS_ONEMASK:  mask_d[wsel] = reg_wdata[2];
                OFS_ALLMASK:  mask_d = reg_wdata[NUM_CH-1:0];
                OFS_UNMASK:   mask_d = '0;
                OFS_RESETALL: begin
                    mask_d  = '1;
                    swreq_d = '0;
                end
                OFS_SWREQ:    swreq_d[wsel] = reg_wdata[2];
                default: ;
            endcase
        end
        mask_d  = mask_d | (tc_hit & ~auto_vec);
        swreq_d = swreq_d & ~tc_hit;
    end

    // Shared registers
    always_ff @(posedge clk) begin
        if (rst) begin
            cmd_q    <= '0;
            mask_q   <= '1;
            swreq_q  <= '0;
            tcflag_q <= '0;
            ptr_hi_q <= 1'b0;
            for (int c = 0; c < NUM_CH; c++) begin
                mode_q[c] <= '0;
                page_q[c] <= '0;
            end
        end else begin
            mask_q   <= mask_d;
            swreq_q  <= swreq_d;
            tcflag_q <= ((rd_stat || clr_all) ? '0 : tcflag_q) | tc_hit;

            if (clr_all || (wr_at && reg_addr == OFS_PTRCLR))
                ptr_hi_q <= 1'b0;
            else if ((reg_wr || reg_rd) && chan_reg)
                ptr_hi_q <= ~ptr_hi_q;

            if (clr_all)
                cmd_q <= '0;
            else if (wr_at && reg_addr == OFS_CMD_STAT)
                cmd_q <= reg_wdata;

            if (wr_at && reg_addr == OFS_MODE)
                mode_q[wsel] <= chan_mode_t'(reg_wdata[BYTE_W-1:CH_W]);

            if (wr_at && page_reg)
                page_q[reg_addr[CH_W-1:0]] <= reg_wdata[PAGE_W-1:0];
        end
    end

    // Read port
    always_ff @(posedge clk) begin
        if (rst) begin
            reg_rdata <= '0;
        end else if (reg_rd) begin
            if (chan_reg) begin
                logic [WORD_W-1:0] w;
                w = reg_addr[0] ? cur_cnt[reg_ch] : cur_addr[reg_ch];
                reg_rdata <= ptr_hi_q ? w[WORD_W-1:BYTE_W] : w[BYTE_W-1:0];
            end else if (reg_addr == OFS_CMD_STAT) begin
                reg_rdata <= {dreq | swreq_q, tcflag_q};
            end else if (page_reg) begin
                reg_rdata <= BYTE_W'(page_q[reg_addr[CH_W-1:0]]);
            end else begin
                reg_rdata <= '0;
            end
        end
    end

    // Transfer sequencer
    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q   <= PH_IDLE;
            dack      <= '0;
            mem_addr  <= '0;
            xfer_kind <= '0;
            tc        <= 1'b0;
        end else begin
            phase_q <= (|grant) ? PH_ACK : PH_IDLE;
            dack    <= grant;
            tc      <= |tc_hit;
            if (|grant) begin
                mem_addr  <= {page_q[gsel], cur_addr[gsel]};
                xfer_kind <= mode_q[gsel].kind;
            end
        end
    end

    AST_ONE_ACK: assert property (@(posedge clk) disable iff (rst)
        $onehot0(dack)); // R13
    AST_ACK_PULSE: assert property (@(posedge clk) disable iff (rst)
        (|dack) |=> !(|dack)); // R13
    AST_DISABLED_IDLE: assert property (@(posedge clk) disable iff (rst)
        cmd_q[CMD_OFF_BIT] |=> !(|dack)); // R8
    AST_TC_WITH_ACK: assert property (@(posedge clk) disable iff (rst)
        tc |-> (|dack)); // R10
    AST_TC_FLAGGED: assert property (@(posedge clk) disable iff (rst)
        tc |-> ((tcflag_q & dack) != '0)); // R11
    AST_TC_MASK_OR_RELOAD: assert property (@(posedge clk) disable iff (rst)
        tc |-> ((dack & (mask_q | auto_vec)) != '0)); // R12
endmodule

// File: tb/dma4_ctrl_tb.sv
`timescale 1ns/1ps
module dma4_ctrl_tb;
    import dma4_pkg::*;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [4:0]  reg_addr = '0;
    logic        reg_wr = 1'b0;
    logic        reg_rd = 1'b0;
    logic [7:0]  reg_wdata = '0;
    logic [7:0]  reg_rdata;
    logic [3:0]  dreq = '0;
    logic [3:0]  dack;
    logic [19:0] mem_addr;
    logic [1:0]  xfer_kind;
    logic        tc;

    int checks = 0;
    int errors = 0;

    logic [1:0]  rec_ch   [32];
    logic [19:0] rec_addr [32];
    logic        rec_tc   [32];
    logic [1:0]  rec_kind [32];
    int          rec_cyc  [32];
    int          nrec;

    always #2.5 clk = ~clk;

    dma4_ctrl u_dut (
        .clk(clk), .rst(rst), .reg_addr(reg_addr), .reg_wr(reg_wr), .reg_rd(reg_rd),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .dreq(dreq), .dack(dack),
        .mem_addr(mem_addr), .xfer_kind(xfer_kind), .tc(tc)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [4:0] a, input logic [7:0] d);
        @(negedge clk);
        reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [4:0] a, output logic [7:0] d);
        @(negedge clk);
        reg_addr = a; reg_rd = 1'b1;
        @(negedge clk);
        reg_rd = 1'b0;
        d = reg_rdata;
    endtask

    task automatic prog(input int ch, input logic [15:0] a, input logic [15:0] n,
                        input logic [3:0] pg, input logic [7:0] md);
        wr(OFS_PTRCLR, 8'h00);
        wr(5'(2*ch), a[7:0]);   wr(5'(2*ch), a[15:8]);
        wr(5'(2*ch+1), n[7:0]); wr(5'(2*ch+1), n[15:8]);
        wr(5'(16+ch), {4'h0, pg});
        wr(OFS_MODE, md);
    endtask

    task automatic watch(input int n);
        nrec = 0;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            if (|dack && nrec < 32) begin
                rec_ch[nrec] = 2'd0;
                for (int k = 0; k < 4; k++) if (dack[k]) rec_ch[nrec] = 2'(k);
                rec_addr[nrec] = mem_addr;
                rec_tc[nrec]   = tc;
                rec_kind[nrec] = xfer_kind;
                rec_cyc[nrec]  = i;
                nrec++;
            end
        end
    endtask

    task automatic t_reset();
        logic [7:0] d;
        chk("R1 dack after reset", int'(dack), 0);
        rd(OFS_CMD_STAT, d);
        chk("R1 status after reset", int'(d), 8'h00);
        dreq = 4'hF;
        watch(6);
        chk("R1 all channels masked", nrec, 0);
        dreq = 4'h0;
    endtask

    task automatic t_bytes();
        logic [7:0] d;
        wr(5'h02, 8'h34); wr(5'h02, 8'h12);
        rd(5'h02, d); chk("R2 R4 address low byte", int'(d), 8'h34);
        rd(5'h02, d); chk("R2 R4 address high byte", int'(d), 8'h12);
        wr(5'h03, 8'h77);
        wr(OFS_PTRCLR, 8'h00);
        wr(5'h03, 8'hCD); wr(5'h03, 8'hAB);
        wr(OFS_PTRCLR, 8'h00);
        rd(5'h03, d); chk("R3 count low after pointer clear", int'(d), 8'hCD);
        rd(5'h03, d); chk("R3 count high after pointer clear", int'(d), 8'hAB);
    endtask

    task automatic t_count();
        logic [7:0] d;
        prog(0, 16'h0200, 16'd3, 4'h5, 8'h44);
        wr(OFS_ONEMASK, 8'h00);
        dreq = 4'b0001;
        watch(20);
        chk("R10 transfers for count 3", nrec, 4);
        for (int i = 0; i < 4; i++) begin
            chk("R9 incrementing address", int'(rec_addr[i]), 20'h50200 + i);
            chk("R10 tc only on last", int'(rec_tc[i]), (i == 3) ? 1 : 0);
        end
        chk("R5 write type on xfer_kind", int'(rec_kind[0]), 1);
        chk("R13 spacing between grants", rec_cyc[1] - rec_cyc[0], 2);
        watch(8);
        chk("R12 self-mask after tc", nrec, 0);
        rd(OFS_CMD_STAT, d); chk("R11 status tc and pending", int'(d), 8'h11);
        rd(OFS_CMD_STAT, d); chk("R11 tc flag cleared by read", int'(d), 8'h10);
        dreq = 4'b0000;
    endtask

    task automatic t_wrap();
        prog(3, 16'hFFFF, 16'd1, 4'hA, 8'h4B);
        wr(OFS_ONEMASK, 8'h03);
        dreq = 4'b1000;
        watch(10);
        dreq = 4'b0000;
        chk("R9 wrap count", nrec, 2);
        chk("R9 first address", int'(rec_addr[0]), 20'hAFFFF);
        chk("R9 wrap keeps page", int'(rec_addr[1]), 20'hA0000);
        chk("R5 read type on xfer_kind", int'(rec_kind[0]), 2);
        prog(2, 16'h0000, 16'd1, 4'h3, 8'h66);
        wr(OFS_ONEMASK, 8'h02);
        dreq = 4'b0100;
        watch(10);
        dreq = 4'b0000;
        chk("R5 decrement first", int'(rec_addr[0]), 20'h30000);
        chk("R5 R9 decrement wraps", int'(rec_addr[1]), 20'h3FFFF);
    endtask

    task automatic t_prio();
        logic [7:0] d;
        rd(OFS_CMD_STAT, d);
        prog(1, 16'h1000, 16'd1, 4'h1, 8'h45);
        prog(2, 16'h2000, 16'd0, 4'h2, 8'h46);
        wr(OFS_UNMASK, 8'h00);
        dreq = 4'b0110;
        watch(12);
        dreq = 4'b0000;
        chk("R13 transfers in priority test", nrec, 3);
        chk("R13 channel 1 first", int'(rec_ch[0]), 1);
        chk("R13 channel 1 second", int'(rec_ch[1]), 1);
        chk("R13 channel 2 after", int'(rec_ch[2]), 2);
        chk("R7 clear-mask enabled channel 2", int'(rec_addr[2]), 20'h22000);
        rd(OFS_CMD_STAT, d); chk("R11 tc flags of two channels", int'(d), 8'h06);
    endtask

    task automatic t_disable();
        logic [7:0] d;
        prog(1, 16'h1000, 16'd0, 4'h1, 8'h45);
        wr(OFS_ONEMASK, 8'h01);
        wr(OFS_CMD_STAT, 8'h04);
        dreq = 4'b0010;
        watch(8);
        chk("R8 no grant while disabled", nrec, 0);
        rd(OFS_CMD_STAT, d); chk("R8 request pending while disabled", int'(d), 8'h20);
        wr(OFS_CMD_STAT, 8'h00);
        watch(8);
        dreq = 4'b0000;
        chk("R8 grant after enable", nrec, 1);
    endtask

    task automatic t_softreq();
        logic [7:0] d;
        rd(OFS_CMD_STAT, d);
        prog(0, 16'h0400, 16'd0, 4'h0, 8'h44);
        wr(OFS_ONEMASK, 8'h04);
        wr(OFS_SWREQ, 8'h04);
        rd(OFS_CMD_STAT, d); chk("R14 software request pending", int'(d), 8'h10);
        wr(OFS_ONEMASK, 8'h00);
        watch(6);
        chk("R14 software request served", nrec, 1);
        chk("R14 served address", int'(rec_addr[0]), 20'h00400);
        rd(OFS_CMD_STAT, d); chk("R14 request cleared at tc", int'(d), 8'h01);
        wr(OFS_SWREQ, 8'h05);
        rd(OFS_CMD_STAT, d); chk("R14 request set on channel 1", int'(d), 8'h20);
        wr(OFS_SWREQ, 8'h01);
        rd(OFS_CMD_STAT, d); chk("R14 request cleared by write", int'(d), 8'h00);
    endtask

    task automatic t_autoinit();
        prog(2, 16'h0100, 16'd1, 4'h0, 8'h56);
        wr(OFS_ONEMASK, 8'h02);
        dreq = 4'b0100;
        watch(10);
        dreq = 4'b0000;
        chk("R12 auto-init keeps running", int'(nrec >= 4), 1);
        chk("R12 addr 0", int'(rec_addr[0]), 20'h00100);
        chk("R12 addr 1 tc", int'(rec_tc[1]), 1);
        chk("R12 reload to base", int'(rec_addr[2]), 20'h00100);
        chk("R12 second period tc", int'(rec_tc[3]), 1);
        wr(OFS_ONEMASK, 8'h06);
    endtask

    task automatic t_allmask_clear();
        logic [7:0] d;
        int only1;
        prog(0, 16'h0800, 16'd5, 4'h0, 8'h44);
        prog(1, 16'h0900, 16'd5, 4'h0, 8'h45);
        wr(OFS_ALLMASK, 8'h0D);
        dreq = 4'b0011;
        watch(6);
        dreq = 4'b0000;
        only1 = 1;
        for (int i = 0; i < nrec; i++) if (rec_ch[i] != 2'd1) only1 = 0;
        chk("R7 all-mask leaves only channel 1", only1 & int'(nrec > 0), 1);
        chk("R6 masked channel 0 gets no ack", int'(rec_addr[0]), 20'h00900);
        wr(5'h00, 8'h11);
        wr(OFS_RESETALL, 8'h00);
        dreq = 4'b0011;
        watch(6);
        chk("R7 master clear masks all", nrec, 0);
        rd(OFS_CMD_STAT, d); chk("R7 master clear status", int'(d), 8'h30);
        dreq = 4'b0000;
        wr(5'h00, 8'h5A); wr(5'h00, 8'hA5);
        rd(5'h00, d); chk("R7 master clear reset byte pointer", int'(d), 8'h5A);
        rd(5'h00, d); chk("R2 high byte after pointer reset", int'(d), 8'hA5);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual hung expected done");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_bytes();
        t_count();
        t_wrap();
        t_prio();
        t_disable();
        t_softreq();
        t_autoinit();
        t_allmask_clear();
        repeat (4) @(negedge clk);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule